// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds one logical register that exists as several physical copies, one for each hardware unit. The copies are arranged as G groups of I instances, and all of them answer at a single bus address. A steering selector register chooses which copy a unicast access targets. A multicast flag in the same selector decides whether a write goes to one copy or to all of them. A presence mask marks copies whose unit is fused off or power-gated. The block terminates accesses to those copies: a read returns zero and a unicast write is dropped.

Agents that share the selector serialize their use of it through a lock register. Reading the lock takes it, and writing 1 gives it back. The block also has a multicast read-modify-write operation. It reads one present copy, computes `(old & ~clear) | set`, writes the result to every present copy, and returns the old value.

The register bus accepts one request per cycle and answers every request exactly one cycle later. Word addresses are: 0 for the selector, 1 for the lock, 2 for the replicated data register, and 3 unmapped.

Top module: `repl_reg_bank`

## Requirements
- R1: A write to address 2 while the multicast flag is set stores the write data in every present copy.
- R2: A write to address 2 while the multicast flag is clear stores the data only in the copy at index group*I+instance. All other copies keep their values.
- R3: A read of address 2 returns the single steered copy, whatever the state of the multicast flag.
- R4: Accesses to a copy whose presence bit is 0 are terminated. A read returns 0, and a unicast write changes nothing. A multicast write skips such copies, so they stay at zero. A copy that was written and later becomes absent keeps its value while reads of it return 0.
- R5: A group ID of G or more, or an instance ID of I or more, is terminated in the same way as an absent copy.
- R6: The selector layout is instance ID in bits [7:0], group ID in bits [15:8] and the multicast flag in bit 31. Other bits read 0, and the value after reset is 0x8000_0000.
- R7: A unicast write to address 2 sets the multicast flag again in the following cycle, whether or not the target copy is present.
- R8: A read of address 1 returns 1 and takes the lock when it is free, and returns 0 while it is held. Writing a word with bit 0 set releases the lock, and writing bit 0 clear has no effect.
- R9: The read-modify-write op reads the lowest-indexed present copy, writes `(old & ~clear) | set` to all present copies, and returns the old value. With no copy present it returns 0 and writes nothing.
- R10: Every request gets `rsp_valid` exactly one cycle later. Writes return 0, and cycles with no request produce no response. Op encoding: 0 and 3 read, 1 write, 2 read-modify-write.
- R11: After reset all copies hold 0, the lock is free and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| present | input | G*I | Presence bit per copy, index group*I+instance |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0/3 read, 1 write, 2 read-modify-write |
| req_addr | input | 2 | Word address (0 selector, 1 lock, 2 data) |
| req_wdata | input | 32 | Write data, or set mask for read-modify-write |
| req_clear | input | 32 | Clear mask for read-modify-write |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 32 | Read data or old value; 0 for writes |

## Verification
The bench steers to absent copies and to IDs just past the configured range. A design that failed to terminate these accesses would return stale data or write into a neighbouring copy. After each unicast write the bench reads the selector back, so a design that left the multicast flag clear would show a missing bit 31. It takes the lock twice in a row and releases it with bit 0 clear, which exposes a lock that re-grants too early or releases on any write. It runs the read-modify-write while the lowest copy is absent, so choosing the wrong source copy shows up in the returned old value.

// File: rtl/repl_bank_pkg.sv
package repl_bank_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2,
    OP_READ2 = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    A_STEER = 2'd0,
    A_LOCK  = 2'd1,
    A_DATA  = 2'd2,
    A_NONE  = 2'd3
  } addr_e;

  typedef struct packed {
    logic       mc;
    logic [7:0] grp;
    logic [7:0] inst;
  } steer_t;

  localparam steer_t STEER_RST = '{mc: 1'b1, grp: 8'd0, inst: 8'd0};

  function automatic logic [DW-1:0] steer_pack(steer_t s);
    return {s.mc, 15'd0, s.grp, s.inst};
  endfunction

  function automatic steer_t steer_unpack(logic [DW-1:0] w);
    steer_t s;
    s.mc   = w[31];
    s.grp  = w[15:8];
    s.inst = w[7:0];
    return s;
  endfunction
endpackage

// File: rtl/repl_steer_decode.sv
module repl_steer_decode
  import repl_bank_pkg::*;
#(
  parameter int G  = 4,
  parameter int I  = 4,
  localparam int N  = G * I,
  localparam int NW = (N > 1) ? $clog2(N) : 1
) (
  input  steer_t          sel,
  input  logic [N-1:0]    present,
  output logic            hit,
  output logic [NW-1:0]   idx
);
  logic in_range;
  int unsigned flat;

  always_comb begin
    in_range = (int'(sel.grp) < G) && (int'(sel.inst) < I);
    flat     = int'(sel.grp) * I + int'(sel.inst);
    idx      = in_range ? NW'(flat) : '0;
    hit      = in_range ? present[idx] : 1'b0;
  end
endmodule

// File: rtl/repl_first_present.sv
module repl_first_present #(
  parameter int N  = 16,
  localparam int NW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  present,
  output logic          found,
  output logic [NW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (present[k]) begin
        found = 1'b1;
        idx   = NW'(k);
      end
    end
  end
endmodule

// File: rtl/repl_inst_array.sv
module repl_inst_array #(
  parameter int N  = 16,
  parameter int DW = 32,
  localparam int NW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  present,
  input  logic          wr_all,
  input  logic          wr_one,
  input  logic [NW-1:0] wr_idx,
  input  logic [DW-1:0] wdata,
  input  logic [NW-1:0] rd_idx_a,
  input  logic [NW-1:0] rd_idx_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b
);
  logic [DW-1:0] copies [N];

  for (genvar g = 0; g < N; g++) begin : g_copy
    logic sel_me;
    assign sel_me = present[g] && (wr_all || (wr_one && (wr_idx == NW'(g))));
    always_ff @(posedge clk) begin
      if (rst)         copies[g] <= '0;
      else if (sel_me) copies[g] <= wdata;
    end
  end

  assign rd_data_a = copies[rd_idx_a];
  assign rd_data_b = copies[rd_idx_b];
endmodule

// File: rtl/repl_lock.sv
module repl_lock (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic give,
  output logic free
);
  logic held;

  assign free = !held;

  always_ff @(posedge clk) begin
    if (rst)       held <= 1'b0;
    else if (give) held <= 1'b0;
    else if (take) held <= 1'b1;
  end
endmodule

// File: rtl/repl_reg_bank.sv
module repl_reg_bank
  import repl_bank_pkg::*;
#(
  parameter int G = 4,
  parameter int I = 4,
  localparam int N  = G * I,
  localparam int NW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  present,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [1:0]    req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [31:0]   req_clear,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata
);
  op_e    op;
  addr_e  addr;
  steer_t steer_q;
  logic   do_rd, do_wr, do_rmw;
  logic   hit, any_present, lock_free;
  logic [NW-1:0] tgt_idx, first_idx;
  logic [DW-1:0] tgt_val, first_val, arr_wdata, rd_next;
  logic   wr_all, wr_one, data_wr;

  assign op     = op_e'(req_op);
  assign addr   = addr_e'(req_addr);
  assign do_wr  = req_valid && (op == OP_WRITE);
  assign do_rmw = req_valid && (op == OP_RMW);
  assign do_rd  = req_valid && (op == OP_READ || op == OP_READ2);
  assign data_wr = do_wr && (addr == A_DATA);

  repl_steer_decode #(.G(G), .I(I)) u_dec (
    .sel(steer_q), .present(present), .hit(hit), .idx(tgt_idx)
  );

  repl_first_present #(.N(N)) u_first (
    .present(present), .found(any_present), .idx(first_idx)
  );

  assign wr_all    = (data_wr && steer_q.mc) || (do_rmw && any_present);
  assign wr_one    = data_wr && !steer_q.mc && hit;
  assign arr_wdata = do_rmw ? ((first_val & ~req_clear) | req_wdata) : req_wdata;

  repl_inst_array #(.N(N), .DW(DW)) u_arr (
    .clk(clk), .rst(rst), .present(present),
    .wr_all(wr_all), .wr_one(wr_one), .wr_idx(tgt_idx), .wdata(arr_wdata),
    .rd_idx_a(tgt_idx), .rd_idx_b(first_idx),
    .rd_data_a(tgt_val), .rd_data_b(first_val)
  );

  repl_lock u_lock (
    .clk(clk), .rst(rst),
    .take(do_rd && addr == A_LOCK),
    .give(do_wr && addr == A_LOCK && req_wdata[0]),
    .free(lock_free)
  );

  // Selector: software writes, and the flag comes back after a unicast write.
  always_ff @(posedge clk) begin
    if (rst)                              steer_q <= STEER_RST;
    else if (do_wr && addr == A_STEER)    steer_q <= steer_unpack(req_wdata);
    else if (data_wr && !steer_q.mc)      steer_q.mc <= 1'b1;
  end

  always_comb begin
    rd_next = '0;
    if (do_rmw) begin
      rd_next = any_present ? first_val : '0;
    end else if (do_rd) begin
      case (addr)
        A_STEER: rd_next = steer_pack(steer_q);
        A_LOCK:  rd_next = {31'd0, lock_free};
        A_DATA:  rd_next = hit ? tgt_val : '0;
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/repl_reg_bank_chk.sv
module repl_reg_bank_chk
  import repl_bank_pkg::*;
#(
  parameter int G = 4,
  parameter int I = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [1:0]  req_op,
  input logic [1:0]  req_addr,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input steer_t      steer_q
);
  logic is_rd, is_wr;
  assign is_rd = req_valid && (req_op == 2'd0 || req_op == 2'd3);
  assign is_wr = req_valid && (req_op == 2'd1);

  // R10
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R10
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R10
  write_returns_zero_chk: assert property (@(posedge clk) disable iff (rst)
    is_wr |=> (rsp_rdata == 32'd0));

  // R8
  lock_second_take_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (is_rd && req_addr == 2'd1) ##1 (is_rd && req_addr == 2'd1) |=> (rsp_rdata == 32'd0));

  // R5
  group_out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
    (is_rd && req_addr == 2'd2 && int'(steer_q.grp) >= G) |=> (rsp_rdata == 32'd0));

  // R5
  inst_out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
    (is_rd && req_addr == 2'd2 && int'(steer_q.inst) >= I) |=> (rsp_rdata == 32'd0));

  // R7
  mc_restored_chk: assert property (@(posedge clk) disable iff (rst)
    (is_wr && req_addr == 2'd2 && !steer_q.mc) |=> steer_q.mc);
endmodule

bind repl_reg_bank repl_reg_bank_chk #(.G(G), .I(I)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .steer_q(steer_q)
);

// File: tb/repl_reg_bank_bench.sv
module repl_reg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int G = 4;
  localparam int I = 4;
  localparam int N = G * I;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] present = 16'hF7F6;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [1:0]  req_addr = 2'd0;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_clear = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // scoreboard
  logic [31:0] exp_q [$];
  string       tag_q [$];

  // requirement model
  logic [31:0] mdl [N];
  logic        m_mc;
  int          m_grp, m_inst;
  bit          m_held;

  always #(CLK_PERIOD / 2) clk = ~clk;

  repl_reg_bank #(.G(G), .I(I)) u_repl_reg_bank (
    .clk(clk), .rst(rst), .present(present), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_clear(req_clear), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit m_hit();
    return (m_grp < G) && (m_inst < I) && present[m_grp * I + m_inst];
  endfunction

  // driver: one request per call, expected result pushed to the scoreboard
  task automatic issue(logic [1:0] op, logic [1:0] addr, logic [31:0] wd,
                       logic [31:0] clr, string tag);
    logic [31:0] e;
    int first;
    e = '0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd; req_clear = clr;
    if (op == 2'd0 || op == 2'd3) begin
      case (addr)
        2'd0: e = {m_mc, 15'd0, 8'(m_grp), 8'(m_inst)};
        2'd1: begin e = m_held ? 32'd0 : 32'd1; m_held = 1'b1; end
        2'd2: e = m_hit() ? mdl[m_grp * I + m_inst] : 32'd0;
        default: e = '0;
      endcase
    end else if (op == 2'd1) begin
      case (addr)
        2'd0: begin m_mc = wd[31]; m_grp = int'(wd[15:8]); m_inst = int'(wd[7:0]); end
        2'd1: if (wd[0]) m_held = 1'b0;
        2'd2: begin
          if (m_mc) begin
            for (int k = 0; k < N; k++) if (present[k]) mdl[k] = wd;
          end else begin
            if (m_hit()) mdl[m_grp * I + m_inst] = wd;
            m_mc = 1'b1;
          end
        end
        default: ;
      endcase
    end else begin
      first = -1;
      for (int k = N - 1; k >= 0; k--) if (present[k]) first = k;
      if (first >= 0) begin
        e = mdl[first];
        for (int k = 0; k < N; k++) if (present[k]) mdl[k] = (e & ~clr) | wd;
      end
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic steer(bit mc, int g, int i, string tag);
    issue(2'd1, 2'd0, {mc, 15'd0, 8'(g), 8'(i)}, '0, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 actual=unexpected response expected=none");
      end else begin
        check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) mdl[k] = '0;
    m_mc = 1'b1; m_grp = 0; m_inst = 0; m_held = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 no response after reset", {31'd0, rsp_valid}, 32'd0);

    issue(2'd0, 2'd0, '0, '0, "R6 selector reset value");
    issue(2'd0, 2'd2, '0, '0, "R4 absent copy read");
    steer(1, 0, 1, "R10 selector write");
    issue(2'd0, 2'd2, '0, '0, "R11 copy zero after reset");

    // multicast write then sweep all copies
    issue(2'd1, 2'd2, 32'hA5A5_0001, '0, "R1 multicast write");
    for (int g = 0; g < G; g++)
      for (int i = 0; i < I; i++) begin
        steer(1, g, i, "R6 steer");
        issue(2'd0, 2'd2, '0, '0, "R1 R4 sweep read");
      end

    // unicast write and flag restore
    steer(0, 1, 2, "R2 steer unicast");
    issue(2'd0, 2'd2, '0, '0, "R3 read with flag clear");
    issue(2'd1, 2'd2, 32'h0000_1234, '0, "R2 unicast write");
    issue(2'd3, 2'd0, '0, '0, "R7 flag restored");
    issue(2'd0, 2'd2, '0, '0, "R2 target updated");
    steer(0, 1, 1, "R2 steer neighbour");
    issue(2'd0, 2'd2, '0, '0, "R3 neighbour unchanged");

    // unicast to absent copy
    steer(0, 0, 3, "R4 steer absent");
    issue(2'd1, 2'd2, 32'hDEAD_BEEF, '0, "R4 dropped write");
    issue(2'd0, 2'd0, '0, '0, "R7 flag restored after dropped write");
    issue(2'd0, 2'd2, '0, '0, "R4 absent still zero");

    // out of range IDs
    steer(1, 4, 0, "R5 steer group past range");
    issue(2'd0, 2'd2, '0, '0, "R5 group out of range");
    steer(0, 0, 4, "R5 steer instance past range");
    issue(2'd1, 2'd2, 32'h0BAD_0BAD, '0, "R5 write out of range");
    issue(2'd0, 2'd2, '0, '0, "R5 instance out of range");
    for (int i = 0; i < I; i++) begin
      steer(1, 1, i, "R5 steer");
      issue(2'd0, 2'd2, '0, '0, "R5 no alias write");
    end
    idle();

    // lock
    issue(2'd0, 2'd1, '0, '0, "R8 lock free grant");
    issue(2'd0, 2'd1, '0, '0, "R8 lock held");
    issue(2'd1, 2'd1, 32'hFFFF_FFFE, '0, "R8 write bit0 clear");
    issue(2'd0, 2'd1, '0, '0, "R8 still held");
    issue(2'd1, 2'd1, 32'd1, '0, "R8 release");
    issue(2'd0, 2'd1, '0, '0, "R8 grant after release");
    issue(2'd1, 2'd1, 32'd1, '0, "R8 release again");

    // read-modify-write
    issue(2'd2, 2'd0, 32'h00F0_0000, 32'h0000_FFFF, "R9 rmw old value");
    steer(1, 1, 2, "R9 steer");
    issue(2'd0, 2'd2, '0, '0, "R9 new value at unicast-written copy");
    idle();
    present = 16'hF7F4;
    issue(2'd2, 2'd0, 32'h0000_0003, 32'hFF00_0000, "R9 rmw lowest moved");
    steer(1, 0, 1, "R9 steer now absent");
    issue(2'd0, 2'd2, '0, '0, "R4 newly absent reads zero");
    idle();
    present = 16'hF7F6;
    issue(2'd0, 2'd2, '0, '0, "R4 restored copy kept value");
    idle();
    present = '0;
    issue(2'd2, 2'd0, 32'hFFFF_FFFF, '0, "R9 rmw none present");
    idle();
    present = 16'hF7F6;
    steer(1, 3, 3, "R9 steer");
    issue(2'd0, 2'd2, '0, '0, "R9 no write when none present");
    idle();
    repeat (3) @(negedge clk);

    check("R10 all responses seen", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule